// File: doc/BRIEF.md
# JTAG Test Access Port with Boundary Scan

This block is the test access port of a small chip. It follows TMS on rising TCK through the sixteen-state TAP controller and holds a 4-bit instruction. The decoded instruction picks which data register is shifted between TDI and TDO. There are four data registers: a 32-bit identification word, a boundary-scan chain of four cells for each pin, a one-bit reset register and a one-bit bypass.

Under EXTEST the pins are driven from the update latches of the chain instead of from the core. There is no high-impedance instruction. To tri-state the pins, a test program loads a 1 into the reset register. The reset register feeds the chip reset request, and while that request is active the pins are forced to tri-state unless EXTEST owns them. Data in every register shifts least-significant bit first.

Top module: `jtag_tap_top`

## Requirements
- R1: The controller changes state on rising TCK following the sixteen-state TAP graph. Five consecutive clocks with TMS high reach Test-Logic-Reset from any state. trstN low forces Test-Logic-Reset asynchronously.
- R2: The instruction register is 4 bits and shifts LSB first. Capture-IR loads 4'b0001, so the first bits out are 1,0,0,0. A new instruction becomes active only at Update-IR.
- R3: Opcode 0x1 selects the 32-bit identification register, laid out as {version[3:0], device[15:0], manufacturer[10:0], 1'b1}. It is captured at Capture-DR and shifted out LSB first. This is the active instruction after reset and after any visit to Test-Logic-Reset.
- R4: Any opcode other than 0x0, 0x1 and 0xC selects the bypass bit. The bypass bit captures 0, so TDO gives 0 followed by TDI delayed by one clock.
- R5: TDO updates on falling TCK. tdoEn is high only in Shift-IR and Shift-DR.
- R6: Opcode 0x0 (EXTEST) selects the boundary chain, 4*NPINS cells long. For pin p, cell 4p holds input data, 4p+1 output data, 4p+2 output enable and 4p+3 pull-up disable. Capture-DR loads pinIn into the input cells and the values currently driven on pinOut, pinOe and pinPud into the other cells.
- R7: Under EXTEST, Update-DR copies the output, enable and pull-up cells into latches that drive pinOut, pinOe and pinPud. The latches hold their value at every other time. They reset to 0.
- R8: The pins follow the latches from the Update-IR that makes EXTEST active, with no Update-DR needed. Under any other instruction the pins follow the core signals.
- R9: Opcode 0xC selects a one-bit reset register loaded from TDI in Shift-DR. It reads 0 after reset. It keeps its value when the instruction changes and clears in Test-Logic-Reset. chipReset is this bit ORed with chipResetIn.
- R10: While chipReset is high and EXTEST is not active, pinOe is all zero. EXTEST latches take precedence over this.
- R11: chipResetIn high drives chipReset high in the same cycle, whatever the TAP state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| trstN | input | 1 | Asynchronous test reset, active low |
| pinIn | input | NPINS | Level seen on each pin |
| coreOut | input | NPINS | Core output data per pin |
| coreOe | input | NPINS | Core output enable per pin |
| corePud | input | NPINS | Core pull-up disable per pin |
| chipResetIn | input | 1 | Other chip reset sources |
| tdo | output | 1 | Serial test data out |
| tdoEn | output | 1 | TDO drive enable |
| pinOut | output | NPINS | Data driven to each pin |
| pinOe | output | NPINS | Output enable to each pin |
| pinPud | output | NPINS | Pull-up disable to each pin |
| chipReset | output | 1 | Internal reset request |

## Verification
The bench reads the identification word at power-up and again after each route into Test-Logic-Reset: a TMS reset taken from the middle of a DR shift, and a trstN pulse taken from Capture-DR. An instruction that survived either reset would show up as the wrong serial word.

Two corner cases target the boundary chain. First, the pins are checked straight after EXTEST loads, before any DR scan; a design that waits for Update-DR would still show core values there. Second, a second EXTEST scan checks that the output cells capture the values the latches are driving; a chain that captured the core signals would return the wrong bits.

The reset register is checked while the instruction moves to bypass and to EXTEST. A design that cleared the bit on instruction change would drop chipReset, and one that let reset override EXTEST would show the wrong pinOe. Bypass is scanned with two opcodes, the all-ones code and an unused one, to catch a missing one-cycle delay.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
  localparam logic [IR_W-1:0] OP_RSTREG = 4'hC;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {
    DR_BYPASS, DR_IDENT, DR_CHAIN, DR_RESET
  } drSel_e;

  typedef struct packed {
    logic   captureDr;
    logic   shiftDr;
    logic   updateDr;
    logic   shiftIr;
    logic   tapReset;
    logic   extestOn;
    drSel_e sel;
  } tapStrobe_t;

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rstN,
  input  logic            tms,
  input  logic            tdi,
  output tapState_e       stateOut,
  output logic [IR_W-1:0] irShift,
  output logic [IR_W-1:0] irActive,
  output tapStrobe_t      strobe
);

  tapState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RESET:  stateNext = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   stateNext = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: stateNext = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: stateNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  stateNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: stateNext = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: stateNext = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: stateNext = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: stateNext = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: stateNext = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: stateNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  stateNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: stateNext = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: stateNext = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: stateNext = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: stateNext = tms ? ST_SEL_DR : ST_IDLE;
      default:   stateNext = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= stateNext;
  end

  // instruction shift stage and active instruction
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift  <= IR_CAPTURE;
      irActive <= OP_IDCODE;
    end else begin
      if (state == ST_CAP_IR)     irShift <= IR_CAPTURE;
      else if (state == ST_SH_IR) irShift <= {tdi, irShift[IR_W-1:1]};

      if (state == ST_RESET)      irActive <= OP_IDCODE;
      else if (state == ST_UPD_IR) irActive <= irShift;
    end
  end

  always_comb begin
    strobe.captureDr = (state == ST_CAP_DR);
    strobe.shiftDr   = (state == ST_SH_DR);
    strobe.updateDr  = (state == ST_UPD_DR);
    strobe.shiftIr   = (state == ST_SH_IR);
    strobe.tapReset  = (state == ST_RESET);
    strobe.extestOn  = (irActive == OP_EXTEST);
    case (irActive)
      OP_EXTEST: strobe.sel = DR_CHAIN;
      OP_IDCODE: strobe.sel = DR_IDENT;
      OP_RSTREG: strobe.sel = DR_RESET;
      default:   strobe.sel = DR_BYPASS;
    endcase
  end

  assign stateOut = state;

endmodule

// File: rtl/jtag_tap_dpath.sv
module jtag_tap_dpath
  import jtag_tap_pkg::*;
#(
  parameter int          NPINS    = 4,
  parameter logic [31:0] ID_VALUE = 32'h1
) (
  input  logic             tck,
  input  logic             rstN,
  input  logic             tdi,
  input  tapStrobe_t       strobe,
  input  logic             irSo,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] coreOut,
  input  logic [NPINS-1:0] coreOe,
  input  logic [NPINS-1:0] corePud,
  input  logic             chipResetIn,
  output logic             tdo,
  output logic             tdoEn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic [NPINS-1:0] pinPud,
  output logic             chipReset
);

  localparam int CELLS   = 4;
  localparam int CHAIN_W = NPINS * CELLS;
  localparam int ID_W    = 32;

  logic [CHAIN_W-1:0] chain, chainCap;
  logic [NPINS-1:0]   cellOut, cellOe, cellPud;
  logic [NPINS-1:0]   updOut, updOe, updPud;
  logic [ID_W-1:0]    idReg;
  logic               bypassBit;
  logic               rstBit;
  logic               drSo;

  // per-pin cell mapping: in, out, enable, pull-up disable
  for (genvar p = 0; p < NPINS; p++) begin : g_cell
    assign chainCap[CELLS*p + 0] = pinIn[p];
    assign chainCap[CELLS*p + 1] = pinOut[p];
    assign chainCap[CELLS*p + 2] = pinOe[p];
    assign chainCap[CELLS*p + 3] = pinPud[p];
    assign cellOut[p] = chain[CELLS*p + 1];
    assign cellOe[p]  = chain[CELLS*p + 2];
    assign cellPud[p] = chain[CELLS*p + 3];
  end

  always_ff @(posedge tck) begin
    if (strobe.sel == DR_CHAIN) begin
      if (strobe.captureDr)    chain <= chainCap;
      else if (strobe.shiftDr) chain <= {tdi, chain[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      updOut <= '0;
      updOe  <= '0;
      updPud <= '0;
    end else if (strobe.updateDr && strobe.sel == DR_CHAIN) begin
      updOut <= cellOut;
      updOe  <= cellOe;
      updPud <= cellPud;
    end
  end

  always_ff @(posedge tck) begin
    if (strobe.sel == DR_IDENT) begin
      if (strobe.captureDr)    idReg <= ID_VALUE;
      else if (strobe.shiftDr) idReg <= {tdi, idReg[ID_W-1:1]};
    end
    if (strobe.sel == DR_BYPASS) begin
      if (strobe.captureDr)    bypassBit <= 1'b0;
      else if (strobe.shiftDr) bypassBit <= tdi;
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                                         rstBit <= 1'b0;
    else if (strobe.tapReset)                          rstBit <= 1'b0;
    else if (strobe.shiftDr && strobe.sel == DR_RESET) rstBit <= tdi;
  end

  always_comb begin
    case (strobe.sel)
      DR_IDENT: drSo = idReg[0];
      DR_CHAIN: drSo = chain[0];
      DR_RESET: drSo = rstBit;
      default:  drSo = bypassBit;
    endcase
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strobe.shiftIr | strobe.shiftDr;
      tdo   <= strobe.shiftIr ? irSo : drSo;
    end
  end

  assign chipReset = rstBit | chipResetIn;
  assign pinOut    = strobe.extestOn ? updOut : coreOut;
  assign pinPud    = strobe.extestOn ? updPud : corePud;
  assign pinOe     = strobe.extestOn ? updOe : (chipReset ? '0 : coreOe);

endmodule

// File: rtl/jtag_tap_top.sv
module jtag_tap_top
  import jtag_tap_pkg::*;
#(
  parameter int          NPINS      = 4,
  parameter bit          USE_TRST   = 1'b1,
  parameter logic [3:0]  ID_VERSION = 4'h2,
  parameter logic [15:0] ID_DEVICE  = 16'hA51C,
  parameter logic [10:0] ID_MAKER   = 11'h0B5
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             trstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] coreOut,
  input  logic [NPINS-1:0] coreOe,
  input  logic [NPINS-1:0] corePud,
  input  logic             chipResetIn,
  output logic             tdo,
  output logic             tdoEn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic [NPINS-1:0] pinPud,
  output logic             chipReset
);

  localparam logic [31:0] ID_VALUE = {ID_VERSION, ID_DEVICE, ID_MAKER, 1'b1};

  logic            rstN;
  tapState_e       tapState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irActive;
  tapStrobe_t      strobe;

  if (USE_TRST) begin : g_trst
    assign rstN = trstN;
  end else begin : g_notrst
    assign rstN = 1'b1;
  end

  jtag_tap_ctrl u_ctrl (
    .tck      (tck),
    .rstN     (rstN),
    .tms      (tms),
    .tdi      (tdi),
    .stateOut (tapState),
    .irShift  (irShift),
    .irActive (irActive),
    .strobe   (strobe)
  );

  jtag_tap_dpath #(
    .NPINS    (NPINS),
    .ID_VALUE (ID_VALUE)
  ) u_dpath (
    .tck         (tck),
    .rstN        (rstN),
    .tdi         (tdi),
    .strobe      (strobe),
    .irSo        (irShift[0]),
    .pinIn       (pinIn),
    .coreOut     (coreOut),
    .coreOe      (coreOe),
    .corePud     (corePud),
    .chipResetIn (chipResetIn),
    .tdo         (tdo),
    .tdoEn       (tdoEn),
    .pinOut      (pinOut),
    .pinOe       (pinOe),
    .pinPud      (pinPud),
    .chipReset   (chipReset)
  );

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
  import jtag_tap_pkg::*;
#(
  parameter int NPINS = 4
) (
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input tapState_e       state,
  input logic [IR_W-1:0] irShift,
  input logic [IR_W-1:0] irActive,
  input tapStrobe_t      strobe,
  input logic            chipResetIn,
  input logic            chipReset,
  input logic [NPINS-1:0] pinOe,
  input logic [NPINS-1:0] pinOut
);

  // R1
  tms_reset_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> state == ST_RESET);

  // R2
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    state == ST_CAP_IR |=> irShift == IR_CAPTURE);

  // R3
  reset_ident_chk: assert property (@(posedge tck) disable iff (!trstN)
    state == ST_RESET |=> irActive == OP_IDCODE);

  // R7
  latch_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.extestOn && !strobe.updateDr)
      |=> (!strobe.extestOn || ($stable(pinOe) && $stable(pinOut))));

  // R10
  reset_tristate_chk: assert property (@(posedge tck) disable iff (!trstN)
    (chipReset && !strobe.extestOn) |-> pinOe == '0);

  // R11
  reset_pass_chk: assert property (@(posedge tck) disable iff (!trstN)
    chipResetIn |-> chipReset);

endmodule

bind jtag_tap_top jtag_tap_chk #(.NPINS(NPINS)) u_chk (
  .tck         (tck),
  .trstN       (trstN),
  .tms         (tms),
  .state       (tapState),
  .irShift     (irShift),
  .irActive    (irActive),
  .strobe      (strobe),
  .chipResetIn (chipResetIn),
  .chipReset   (chipReset),
  .pinOe       (pinOe),
  .pinOut      (pinOut)
);

// File: tb/sim_jtag_tap_top.sv
module sim_jtag_tap_top;

  localparam int NPINS = 4;
  localparam int CW    = 4 * NPINS;
  localparam logic [31:0] ID_EXP = {4'h2, 16'hA51C, 11'h0B5, 1'b1};

  logic tck = 1'b0;
  logic tms, tdi, trstN, chipResetIn;
  logic [NPINS-1:0] pinIn, coreOut, coreOe, corePud;
  logic tdo, tdoEn, chipReset;
  logic [NPINS-1:0] pinOut, pinOe, pinPud;

  always #4 tck = ~tck;

  jtag_tap_top u0 (
    .tck(tck), .tms(tms), .tdi(tdi), .trstN(trstN),
    .pinIn(pinIn), .coreOut(coreOut), .coreOe(coreOe), .corePud(corePud),
    .chipResetIn(chipResetIn), .tdo(tdo), .tdoEn(tdoEn),
    .pinOut(pinOut), .pinOe(pinOe), .pinPud(pinPud), .chipReset(chipReset)
  );

  typedef struct {
    logic  val;
    logic  care;
    string req;
  } expBit_t;

  expBit_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected bit per falling edge spent in a shift state
  always @(negedge tck) begin
    #2;
    if (tdoEn === 1'b1) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "tdoEn high with no shift expected", 1, 0);
      end else begin
        expBit_t e;
        e = expQ.pop_front();
        if (e.care) check(tdo === e.val, e.req, "tdo bit", tdo, e.val);
      end
    end
  end

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic pushBits(input int n, input logic [63:0] v,
                          input bit care, input string req);
    for (int i = 0; i < n; i++) begin
      expBit_t e;
      e.val = v[i]; e.care = care; e.req = req;
      expQ.push_back(e);
    end
  endtask

  // from Run-Test/Idle, scan n bits through the data register, back to idle
  task automatic scanDr(input int n, input logic [63:0] din,
                        input logic [63:0] expOut, input string req);
    tick(1, 0); tick(0, 0); tick(0, 0);
    pushBits(n, expOut, 1'b1, req);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scanIr(input logic [3:0] op);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    pushBits(4, 64'h1, 1'b1, "R2");
    for (int i = 0; i < 4; i++) tick(i == 3, op[i]);
    tick(1, 0); tick(0, 0);
  endtask

  function automatic logic [63:0] packCells(input logic [NPINS-1:0] in,
      input logic [NPINS-1:0] o, input logic [NPINS-1:0] oe,
      input logic [NPINS-1:0] pud);
    logic [63:0] r = '0;
    for (int p = 0; p < NPINS; p++) begin
      r[4*p+0] = in[p];
      r[4*p+1] = o[p];
      r[4*p+2] = oe[p];
      r[4*p+3] = pud[p];
    end
    return r;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    trstN = 0; tms = 1; tdi = 0; chipResetIn = 0;
    pinIn = 4'b1010; coreOut = 4'b0110; coreOe = 4'b1111; corePud = 4'b0011;
    repeat (3) @(posedge tck);
    #1;
    check(tdoEn == 0, "R5", "tdoEn in reset", tdoEn, 0);
    check(chipReset == 0, "R9", "chipReset in reset", chipReset, 0);
    check(pinOe == coreOe && pinOut == coreOut, "R8", "pins follow core",
          {pinOe, pinOut}, {coreOe, coreOut});
    trstN = 1;
    tick(0, 0);

    // R3: identification word after power-up
    scanDr(32, 64'h0, {32'h0, ID_EXP}, "R3");

    // R4: bypass with all-ones and an unused opcode
    scanIr(4'hF);
    d = 64'b101101;
    scanDr(6, d, {d[62:0], 1'b0}, "R4");
    scanIr(4'h7);
    d = 64'b0011;
    scanDr(4, d, {d[62:0], 1'b0}, "R4");

    // R8: EXTEST drives reset latches immediately
    scanIr(4'h0);
    check(pinOe == 0 && pinOut == 0 && pinPud == 0, "R8",
          "pins from latches at Update-IR", {pinOe, pinOut, pinPud}, 0);

    // R6/R7: first chain scan
    scanDr(CW, packCells('0, 4'b1001, 4'b0111, 4'b1100),
           packCells(pinIn, '0, '0, '0), "R6");
    check(pinOut == 4'b1001, "R7", "pinOut after Update-DR", pinOut, 4'b1001);
    check(pinOe == 4'b0111, "R7", "pinOe after Update-DR", pinOe, 4'b0111);
    check(pinPud == 4'b1100, "R7", "pinPud after Update-DR", pinPud, 4'b1100);

    // R6: second scan captures driven latch values and new input levels
    pinIn = 4'b0101;
    scanDr(CW, packCells('0, 4'b0000, 4'b1111, 4'b0000),
           packCells(4'b0101, 4'b1001, 4'b0111, 4'b1100), "R6");
    check(pinOe == 4'b1111 && pinOut == 0 && pinPud == 0, "R7",
          "latches after second update", {pinOe, pinOut, pinPud}, 12'hF00);

    // R8: back to core under another instruction
    scanIr(4'h1);
    check(pinOut == coreOut && pinOe == coreOe && pinPud == corePud, "R8",
          "pins follow core after EXTEST", {pinOut, pinOe, pinPud},
          {coreOut, coreOe, corePud});

    // R9/R10: reset register
    scanIr(4'hC);
    scanDr(1, 64'h1, 64'h0, "R9");
    check(chipReset == 1, "R9", "chipReset from reset register", chipReset, 1);
    check(pinOe == 0, "R10", "pins tri-stated in reset", pinOe, 0);
    scanIr(4'hF);
    check(chipReset == 1, "R9", "reset bit held over instruction change", chipReset, 1);
    scanIr(4'h0);
    check(pinOe == 4'b1111, "R10", "EXTEST latches win over reset", pinOe, 4'b1111);
    repeat (5) tick(1, 0);
    tick(0, 0);
    check(chipReset == 0, "R9", "reset bit cleared by TAP reset", chipReset, 0);
    check(pinOe == coreOe, "R10", "pins released after reset", pinOe, coreOe);

    // R1: TMS reset from inside Shift-DR, then identification is default again
    scanIr(4'hF);
    tick(1, 0); tick(0, 0); tick(0, 0);
    pushBits(3, 64'h0, 1'b0, "R1");
    tick(0, 0); tick(0, 0);
    repeat (5) tick(1, 0);
    tick(0, 0);
    scanDr(32, 64'h0, {32'h0, ID_EXP}, "R1");

    // R11: external reset source
    chipResetIn = 1;
    #1;
    check(chipReset == 1, "R11", "chipResetIn passes through", chipReset, 1);
    check(pinOe == 0, "R10", "tri-state on external reset", pinOe, 0);
    chipResetIn = 0;

    // R1: asynchronous trstN from Capture-DR under bypass
    scanIr(4'hF);
    tick(1, 0); tick(0, 0);
    trstN = 0;
    #2;
    trstN = 1;
    tick(0, 0);
    scanDr(32, 64'h0, {32'h0, ID_EXP}, "R1");

    repeat (2) @(posedge tck);
    check(expQ.size() == 0, "R5", "all expected shift bits seen", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule